// File: doc/BRIEF.md
# Shared-Timebase Capture/Compare Array

This block is a timer peripheral built around one free-running 16-bit counter that six channels share. A source selector sets how often the counter steps. The choices are the system clock divided by 12 or by 4, the undivided system clock, a pulse from a neighbouring timer's overflow, rising edges of an external clock pin, and an external oscillator tick divided by 8. Every source becomes a one-cycle enable in the system clock domain. The counter steps only while the run bit is set.

Each channel holds a mode, a 16-bit value register and one output pin. A channel can capture the counter on selected edges of its input pin. It can raise its flag when the counter reaches its value. It can toggle its pin on that match. It can also drive 8-bit or 16-bit pulse-width modulation with a buffered compare value. The last channel can also act as a watchdog, and it leaves reset in that mode with the counter running. Software must keep moving its deadline forward. Otherwise a one-cycle reset pulse is issued.

A plain write/read port reaches the control word, the counter, each channel's mode and value, and the flag word.

Top module: `cap_cmp_array`

## Requirements
- R1: After reset the control word reads 0x0008 (run=1, source code 0), the counter reads 0, channel 5's mode reads 0x0006 (watchdog), the other channel modes read 0, and flags, pins and the watchdog reset are all 0.
- R2: The control word is at address 0: bits 2:0 hold the source and bit 3 holds run. The source codes are 0=sysclk/12, 1=sysclk/4, 2=timer-0 overflow pulse, 3=external clock rising edge (two-flop synchronised), 4=every cycle and 5=every 8th oscillator tick. While run=1, the counter at address 1 steps by one on each tick and wraps from 0xFFFF to 0. While run=0 it holds. A write to address 1 loads it.
- R3: Channel i has its mode word at address 2+2i and its value at 3+2i. Mode bits 2:0 hold the mode and bits 3 and 4 enable rising and falling capture. In capture mode (code 1), an enabled edge on cap_i[i] copies the counter into the value register and sets flag i. An edge that is not enabled does nothing.
- R4: In software-timer mode (code 2), flag i sets on the tick that brings the counter to the value, and the pin stays low.
- R5: In toggle-output mode (code 3), the pin inverts on every such match and flag i sets. Writing the mode word clears the pin.
- R6: In 8-bit PWM (code 4), the pin is high when the counter's low byte is greater than or equal to the active compare byte. A value write only updates a shadow copy. The shadow moves to the active compare when a tick wraps the low byte from 0xFF, or when the mode word is written.
- R7: In 16-bit PWM (code 5), the pin is high when the counter is greater than or equal to the active compare. The shadow moves on a tick that wraps the full counter, or on a mode write.
- R8: In watchdog mode (code 6, channel 5 only), wdt_rst_o pulses for one cycle on the tick that brings the counter's high byte to the compare byte. A value write sets the compare byte to the current high byte plus the written low byte, and the value register reads back that byte.
- R9: While run=1, a write that would move channel 5 out of watchdog mode is ignored. While run=0, the write takes effect.
- R10: The flag word at address 14 reads the flags in bits 5:0 and also drives flags_o. Writing 1 to a bit clears that bit and writing 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i (combinational) |
| t0_ovf_i | input | 1 | Overflow pulse from a neighbouring timer |
| ext_clk_i | input | 1 | Asynchronous external count clock |
| osc_tick_i | input | 1 | One-cycle tick per external oscillator cycle |
| cap_i | input | 6 | Per-channel capture inputs |
| cex_o | output | 6 | Per-channel output pins |
| flags_o | output | 6 | Per-channel match/capture flags |
| wdt_rst_o | output | 1 | One-cycle watchdog reset pulse |

## Verification
The hardest case is the buffered PWM compare. The old and new compare values must both be seen around the exact tick where the low byte wraps, and a free-running source makes that tick hard to place. The bench therefore uses the timer-0 overflow input as a manual step. It loads the counter just below the wrap, writes a new shadow value, and checks the pin before the wrap (old compare still active) and after it (new compare active). The watchdog pulse is reached in a similar way: the counter is parked a few counts below a high-byte boundary, the deadline is re-armed to that boundary, and the counter is released on the every-cycle source so the pulse lands on a cycle the bench can predict.

// File: rtl/cca_pkg.sv
package cca_pkg;

    typedef enum logic [2:0] {
        MD_OFF   = 3'd0,
        MD_CAP   = 3'd1,
        MD_SWT   = 3'd2,
        MD_HSO   = 3'd3,
        MD_PWM8  = 3'd4,
        MD_PWM16 = 3'd5,
        MD_WDOG  = 3'd6
    } mode_e;

    typedef enum logic [2:0] {
        SRC_DIV_SLOW = 3'd0,
        SRC_DIV_FAST = 3'd1,
        SRC_T0       = 3'd2,
        SRC_EXT      = 3'd3,
        SRC_SYS      = 3'd4,
        SRC_OSC      = 3'd5
    } src_e;

endpackage

// File: rtl/cca_tick_gen.sv
module cca_tick_gen
    import cca_pkg::*;
#(
    parameter int DIV_SLOW = 12,
    parameter int DIV_FAST = 4,
    parameter int DIV_OSC  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  src_e src_i,
    input  logic t0_ovf_i,
    input  logic ext_clk_i,
    input  logic osc_tick_i,
    output logic tick_o
);
    localparam int SW = (DIV_SLOW > 1) ? $clog2(DIV_SLOW) : 1;
    localparam int FW = (DIV_FAST > 1) ? $clog2(DIV_FAST) : 1;
    localparam int OW = (DIV_OSC  > 1) ? $clog2(DIV_OSC)  : 1;

    typedef struct packed {
        logic [SW-1:0] slow;
        logic [FW-1:0] fast;
        logic [OW-1:0] osc;
        logic [2:0]    ext;
    } tg_st;

    tg_st st_d, st_q;
    logic slow_p, fast_p, osc_p, ext_p;

    always_comb begin
        st_d   = st_q;
        slow_p = (st_q.slow == SW'(DIV_SLOW - 1));
        fast_p = (st_q.fast == FW'(DIV_FAST - 1));
        osc_p  = osc_tick_i && (st_q.osc == OW'(DIV_OSC - 1));
        ext_p  = st_q.ext[1] && !st_q.ext[2];

        st_d.slow = slow_p ? '0 : st_q.slow + 1'b1;
        st_d.fast = fast_p ? '0 : st_q.fast + 1'b1;
        if (osc_tick_i) begin
            st_d.osc = osc_p ? '0 : st_q.osc + 1'b1;
        end
        st_d.ext = {st_q.ext[1:0], ext_clk_i};

        case (src_i)
            SRC_DIV_SLOW: tick_o = slow_p;
            SRC_DIV_FAST: tick_o = fast_p;
            SRC_T0:       tick_o = t0_ovf_i;
            SRC_EXT:      tick_o = ext_p;
            SRC_SYS:      tick_o = 1'b1;
            SRC_OSC:      tick_o = osc_p;
            default:      tick_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/cca_channel.sv
module cca_channel
    import cca_pkg::*;
#(
    parameter int         CW           = 16,
    parameter bit         IS_WDT       = 1'b0,
    parameter logic [7:0] WDT_OFS_INIT = 8'hFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          tick_i,
    input  logic [CW-1:0] cnt_i,
    input  logic          cap_i,
    input  logic          mode_we_i,
    input  logic          val_we_i,
    input  logic [CW-1:0] wdata_i,
    output logic [CW-1:0] cfg_o,
    output logic [CW-1:0] val_o,
    output logic          pin_o,
    output logic          evt_o,
    output logic          wdt_o
);
    localparam int HI = CW - 8;

    typedef struct packed {
        mode_e         mode;
        logic          rise;
        logic          fall;
        logic [CW-1:0] val;
        logic [CW-1:0] act;
        logic          pin;
        logic [2:0]    sync;
        logic          wdt;
    } ch_st;

    ch_st st_d, st_q;
    logic [CW-1:0] cnt_inc;
    logic rise_e, fall_e, match, wd_hit, lo_wrap, full_wrap, locked, bad_mode;

    always_comb begin
        st_d      = st_q;
        evt_o     = 1'b0;
        cnt_inc   = cnt_i + 1'b1;
        rise_e    = st_q.sync[1] && !st_q.sync[2];
        fall_e    = !st_q.sync[1] && st_q.sync[2];
        match     = tick_i && (cnt_inc == st_q.val);
        wd_hit    = tick_i && (cnt_inc[CW-1:HI] == st_q.val[7:0])
                           && (cnt_inc[CW-1:HI] != cnt_i[CW-1:HI]);
        lo_wrap   = tick_i && (cnt_i[7:0] == 8'hFF);
        full_wrap = tick_i && (&cnt_i);

        st_d.sync = {st_q.sync[1:0], cap_i};
        st_d.wdt  = 1'b0;

        case (st_q.mode)
            MD_CAP: begin
                if ((st_q.rise && rise_e) || (st_q.fall && fall_e)) begin
                    st_d.val = cnt_i;
                    evt_o    = 1'b1;
                end
            end
            MD_SWT: evt_o = match;
            MD_HSO: begin
                if (match) begin
                    st_d.pin = !st_q.pin;
                    evt_o    = 1'b1;
                end
            end
            MD_PWM8: begin
                if (lo_wrap) st_d.act = {{HI{1'b0}}, st_q.val[7:0]};
            end
            MD_PWM16: begin
                if (full_wrap) st_d.act = st_q.val;
            end
            MD_WDOG: st_d.wdt = IS_WDT && wd_hit;
            default: ;
        endcase

        if (val_we_i) begin
            if (IS_WDT && st_q.mode == MD_WDOG) begin
                st_d.val = {{HI{1'b0}}, cnt_i[CW-1:HI] + wdata_i[7:0]};
            end else begin
                st_d.val = wdata_i;
            end
        end

        bad_mode = (wdata_i[2:0] == 3'd7) || (!IS_WDT && wdata_i[2:0] == 3'd6);
        locked   = IS_WDT && (st_q.mode == MD_WDOG) && run_i
                   && (wdata_i[2:0] != 3'd6);
        if (mode_we_i && !locked) begin
            st_d.mode = bad_mode ? MD_OFF : mode_e'(wdata_i[2:0]);
            st_d.rise = wdata_i[3];
            st_d.fall = wdata_i[4];
            st_d.act  = (wdata_i[2:0] == 3'd4) ? {{HI{1'b0}}, st_q.val[7:0]} : st_q.val;
            st_d.pin  = 1'b0;
        end

        case (st_q.mode)
            MD_HSO:   pin_o = st_q.pin;
            MD_PWM8:  pin_o = (cnt_i[7:0] >= st_q.act[7:0]);
            MD_PWM16: pin_o = (cnt_i >= st_q.act);
            default:  pin_o = 1'b0;
        endcase

        cfg_o = {{(CW-5){1'b0}}, st_q.fall, st_q.rise, st_q.mode};
        val_o = st_q.val;
        wdt_o = st_q.wdt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mode <= IS_WDT ? MD_WDOG : MD_OFF;
            st_q.val  <= IS_WDT ? {{HI{1'b0}}, WDT_OFS_INIT} : '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/cap_cmp_array.sv
module cap_cmp_array
    import cca_pkg::*;
#(
    parameter int         NCH          = 6,
    parameter int         CW           = 16,
    parameter int         DIV_SLOW     = 12,
    parameter int         DIV_FAST     = 4,
    parameter int         DIV_OSC      = 8,
    parameter logic [7:0] WDT_OFS_INIT = 8'hFF,
    localparam int        NREG         = 2 * NCH + 3,
    localparam int        AW           = $clog2(NREG)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en_i,
    input  logic [AW-1:0]  addr_i,
    input  logic [CW-1:0]  wdata_i,
    output logic [CW-1:0]  rdata_o,
    input  logic           t0_ovf_i,
    input  logic           ext_clk_i,
    input  logic           osc_tick_i,
    input  logic [NCH-1:0] cap_i,
    output logic [NCH-1:0] cex_o,
    output logic [NCH-1:0] flags_o,
    output logic           wdt_rst_o
);
    localparam logic [AW-1:0] A_CTRL = AW'(0);
    localparam logic [AW-1:0] A_CNT  = AW'(1);
    localparam logic [AW-1:0] A_FLAG = AW'(2 * NCH + 2);

    typedef struct packed {
        logic           run;
        src_e           src;
        logic [CW-1:0]  cnt;
        logic [NCH-1:0] flags;
    } top_st;

    top_st st_d, st_q;
    logic src_tick, ch_tick, cnt_wr, ctrl_wr, flag_wr, wd_armed;
    logic [CW-1:0]  ch_cfg [NCH];
    logic [CW-1:0]  ch_val [NCH];
    logic [NCH-1:0] ch_evt, ch_wdt;

    cca_tick_gen #(
        .DIV_SLOW (DIV_SLOW),
        .DIV_FAST (DIV_FAST),
        .DIV_OSC  (DIV_OSC)
    ) u_tick (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_i      (st_q.src),
        .t0_ovf_i   (t0_ovf_i),
        .ext_clk_i  (ext_clk_i),
        .osc_tick_i (osc_tick_i),
        .tick_o     (src_tick)
    );

    assign cnt_wr  = wr_en_i && (addr_i == A_CNT);
    assign ctrl_wr = wr_en_i && (addr_i == A_CTRL);
    assign flag_wr = wr_en_i && (addr_i == A_FLAG);
    assign ch_tick = st_q.run && src_tick && !cnt_wr;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        cca_channel #(
            .CW           (CW),
            .IS_WDT       (i == NCH - 1),
            .WDT_OFS_INIT (WDT_OFS_INIT)
        ) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .run_i     (st_q.run),
            .tick_i    (ch_tick),
            .cnt_i     (st_q.cnt),
            .cap_i     (cap_i[i]),
            .mode_we_i (wr_en_i && (addr_i == AW'(2 + 2 * i))),
            .val_we_i  (wr_en_i && (addr_i == AW'(3 + 2 * i))),
            .wdata_i   (wdata_i),
            .cfg_o     (ch_cfg[i]),
            .val_o     (ch_val[i]),
            .pin_o     (cex_o[i]),
            .evt_o     (ch_evt[i]),
            .wdt_o     (ch_wdt[i])
        );
    end

    always_comb begin
        st_d = st_q;
        if (ctrl_wr) begin
            st_d.run = wdata_i[3];
            st_d.src = src_e'(wdata_i[2:0]);
        end
        if (cnt_wr) begin
            st_d.cnt = wdata_i;
        end else if (ch_tick) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        st_d.flags = (st_q.flags & ~(flag_wr ? wdata_i[NCH-1:0] : '0)) | ch_evt;
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == A_CTRL) rdata_o = CW'({st_q.run, st_q.src});
        if (addr_i == A_CNT)  rdata_o = st_q.cnt;
        if (addr_i == A_FLAG) rdata_o = CW'(st_q.flags);
        for (int i = 0; i < NCH; i++) begin
            if (addr_i == AW'(2 + 2 * i)) rdata_o = ch_cfg[i];
            if (addr_i == AW'(3 + 2 * i)) rdata_o = ch_val[i];
        end
    end

    assign flags_o   = st_q.flags;
    assign wdt_rst_o = |ch_wdt;
    assign wd_armed  = (ch_cfg[NCH-1][2:0] == 3'd6);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.run <= 1'b1;
            st_q.src <= SRC_DIV_SLOW;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/cca_checker.sv
module cca_checker #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run,
    input logic          tick,
    input logic          cnt_wr,
    input logic [CW-1:0] cnt,
    input logic          wd_armed,
    input logic          wdt_rst
);
    // R2: a granted tick advances the counter by exactly one
    assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt == $past(cnt) + 1'b1));

    // R2: with no tick and no load the counter holds
    assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_wr) |=> $stable(cnt));

    // R8: the watchdog reset lasts a single cycle
    assert_wdt_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |=> !wdt_rst);

    // R8: no reset pulse follows a cycle spent outside watchdog mode
    assert_wdt_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wd_armed |=> !wdt_rst);

    // R9: watchdog mode cannot be left while the counter runs
    assert_wdt_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && wd_armed) |=> wd_armed);
endmodule

bind cap_cmp_array cca_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (st_q.run),
    .tick     (ch_tick),
    .cnt_wr   (cnt_wr),
    .cnt      (st_q.cnt),
    .wd_armed (wd_armed),
    .wdt_rst  (wdt_rst_o)
);

// File: tb/tb_cap_cmp_array.sv
module tb_cap_cmp_array;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        t0 = 1'b0, ext = 1'b0, osc = 1'b0;
    logic [5:0]  cap = '0;
    logic [5:0]  cex, flags;
    logic        wdt;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = !clk;

    cap_cmp_array dut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .t0_ovf_i(t0), .ext_clk_i(ext),
        .osc_tick_i(osc), .cap_i(cap), .cex_o(cex), .flags_o(flags),
        .wdt_rst_o(wdt)
    );

    // {mode, compare, counter, expected pin}
    localparam logic [35:0] VECS [10] = '{
        {3'd4, 16'h0080, 16'h007F, 1'b0},
        {3'd4, 16'h0080, 16'h0080, 1'b1},
        {3'd4, 16'h0080, 16'h12FF, 1'b1},
        {3'd4, 16'h0000, 16'h0000, 1'b1},
        {3'd4, 16'h00FF, 16'hAAFE, 1'b0},
        {3'd4, 16'h0100, 16'h0005, 1'b1},
        {3'd5, 16'h8000, 16'h7FFF, 1'b0},
        {3'd5, 16'h8000, 16'h8000, 1'b1},
        {3'd5, 16'hFFFF, 16'hFFFE, 1'b0},
        {3'd5, 16'h0100, 16'h00FF, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        wr_en = 1'b1;
        addr  = 4'(a);
        wdata = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [15:0] v);
        addr = 4'(a);
        #1 v = rdata;
    endtask

    task automatic t0_pulse();
        t0 = 1'b1;
        @(negedge clk);
        t0 = 1'b0;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(1, v);  chk("R1 counter", v, 16'h0000);
        rd(0, v);  chk("R1 control", v, 16'h0008);
        rd(12, v); chk("R1 ch5 mode", v, 16'h0006);
        rd(2, v);  chk("R1 ch0 mode", v, 16'h0000);
        rd(14, v); chk("R1 flags", v, 16'h0000);
        chk("R1 pins", {cex, flags, wdt}, 0);

        // R9 lock while running, release while stopped
        wr(12, 0); rd(12, v); chk("R9 locked", v, 16'h0006);
        wr(0, 4);
        wr(12, 0); rd(12, v); chk("R9 unlocked", v, 16'h0000);

        // R6/R7 vector walk on channel 0
        foreach (VECS[k]) begin
            wr(3, int'(VECS[k][32:17]));
            wr(2, int'(VECS[k][35:33]));
            wr(1, int'(VECS[k][16:1]));
            chk(VECS[k][35:33] == 3'd4 ? "R6 vector" : "R7 vector",
                cex[0], VECS[k][0]);
        end

        // R6 shadow reload only at low-byte wrap
        wr(3, 16'h80); wr(2, 4); wr(3, 16'h10);
        wr(1, 16'h0050); chk("R6 old compare kept", cex[0], 0);
        wr(1, 16'h00FE); wr(0, 16'hA);
        t0_pulse(); chk("R6 before wrap", cex[0], 1);
        t0_pulse(); chk("R6 after wrap", cex[0], 0);
        wr(0, 2); wr(1, 16'h0050); chk("R6 new compare", cex[0], 1);

        // R5 toggle output on channel 1, R10 flag clear
        wr(5, 3); wr(4, 3); wr(1, 0); wr(0, 16'hA);
        t0_pulse(); t0_pulse();
        chk("R5 before match", {cex[1], flags[1]}, 0);
        t0_pulse(); chk("R5 toggled", {cex[1], flags[1]}, 2'b11);
        t0_pulse(); chk("R5 no second toggle", cex[1], 1);
        wr(14, 16'h2); rd(14, v); chk("R10 cleared", v[1], 0);
        wr(1, 2); t0_pulse(); chk("R5 toggle back", {cex[1], flags[1]}, 2'b01);
        wr(14, 16'h1); rd(14, v); chk("R10 zero bit keeps flag", v[1], 1);

        // R4 software timer on channel 2
        wr(0, 2); wr(7, 16'h10); wr(6, 2); wr(1, 16'h0E); wr(0, 16'hA);
        t0_pulse(); chk("R4 no early flag", flags[2], 0);
        t0_pulse(); chk("R4 flag on match", flags[2], 1);
        chk("R4 pin quiet", cex[2], 0);

        // R3 capture on channel 3
        wr(0, 2); wr(8, 9); wr(1, 16'h1234);
        cap[3] = 1'b1; repeat (4) @(negedge clk);
        rd(9, v); chk("R3 rise capture", v, 16'h1234);
        chk("R3 flag", flags[3], 1);
        wr(14, 16'h8); wr(1, 16'h5678);
        cap[3] = 1'b0; repeat (4) @(negedge clk);
        rd(9, v); chk("R3 fall ignored", v, 16'h1234);
        chk("R3 no flag", flags[3], 0);
        wr(8, 17); wr(1, 16'h9ABC);
        cap[3] = 1'b1; repeat (4) @(negedge clk);
        rd(9, v); chk("R3 rise ignored", v, 16'h1234);
        cap[3] = 1'b0; repeat (4) @(negedge clk);
        rd(9, v); chk("R3 fall capture", v, 16'h9ABC);

        // R2 clock sources
        wr(0, 0); wr(1, 0); wr(0, 8); repeat (120) @(negedge clk);
        rd(1, v); chk("R2 div12", v, 10);
        wr(0, 1); wr(1, 0); wr(0, 9); repeat (40) @(negedge clk);
        rd(1, v); chk("R2 div4", v, 10);
        wr(0, 4); wr(1, 0); wr(0, 12); repeat (25) @(negedge clk);
        rd(1, v); chk("R2 sysclk", v, 25);
        wr(0, 5); wr(1, 0); wr(0, 13);
        osc = 1'b1; repeat (80) @(negedge clk); osc = 1'b0;
        repeat (2) @(negedge clk);
        rd(1, v); chk("R2 osc/8", v, 10);
        wr(0, 3); wr(1, 0); wr(0, 11);
        for (int e = 0; e < 5; e++) begin
            ext = 1'b1; repeat (4) @(negedge clk);
            ext = 1'b0; repeat (4) @(negedge clk);
        end
        rd(1, v); chk("R2 ext edges", v, 5);
        wr(0, 4); wr(1, 16'h0777); repeat (10) @(negedge clk);
        rd(1, v); chk("R2 hold when stopped", v, 16'h0777);
        wr(1, 16'hFFFF); wr(0, 12); @(negedge clk);
        rd(1, v); chk("R2 wrap", v, 0);

        // R8 watchdog re-arm and pulse
        wr(0, 4); wr(12, 6); rd(12, v); chk("R9 re-enable stopped", v, 6);
        wr(1, 16'h3400); wr(13, 16'h10);
        rd(13, v); chk("R8 re-arm byte", v, 16'h0044);
        wr(1, 16'h00F0); wr(13, 1); wr(0, 12);
        repeat (15) @(negedge clk); chk("R8 before boundary", wdt, 0);
        @(negedge clk); chk("R8 pulse", wdt, 1);
        @(negedge clk); chk("R8 pulse one cycle", wdt, 0);
        wr(12, 0); rd(12, v); chk("R9 locked again", v, 6);
        wr(0, 4);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule